// File: doc/BRIEF.md
# Microsecond Event Timestamp Generator

This block keeps a free-running time count that advances by one every microsecond, derived from the system clock through a prescaler. Events in a 16-bit word stream carry only the low field of that count (15 bits by default, so the field rolls over roughly every 32.8 ms). The block therefore raises a one-cycle wrap marker each time the low field rolls over. It also keeps an upper wrap counter, so that the receiving side can rebuild the full 32-bit time as the wrap count joined to the low field.

A one-cycle timestamp-reset command clears the whole count and raises a separate reset marker of its own. For multi-device synchronisation the block works in one of two modes. In master mode it drives a 10 kHz square wave that is locked to the count. In slave mode it takes an external 10 kHz clock and snaps the count forward to the next 100 µs boundary on each rising edge.

Top module: `ust_timestamp_gen`

## Requirements
- R1: The full count increments by exactly one every CLK_PER_US clock cycles. The first increment lands on the CLK_PER_US-th rising clock edge after rst_ni is released.
- R2: ts_low_o always equals the lowest TS_LOW_W bits of ts_full_o. ts_full_o is the wrap counter (upper WRAP_W bits) concatenated above the low field.
- R3: When the low field rolls over from all-ones to zero, the wrap counter gains one. In that same cycle, the first cycle in which the new count is visible, wrap_mark_o is high for exactly one cycle.
- R4: The clock edge that samples ts_reset_i high clears the full count and restarts the prescaler. reset_mark_o is high for one cycle right after that edge, while the count reads zero. The next increment follows CLK_PER_US edges later.
- R5: A reset command overrides a rollover or an alignment on the same edge. The count becomes zero and wrap_mark_o stays low.
- R6: In master mode (sync_master_i = 1), sync_out_o is high while the count modulo SYNC_US (100) lies in 0..49 and low while it lies in 50..99. This gives a 10 kHz, 50 % duty wave locked to the count.
- R7: In slave mode, sync_in_i passes through a two-flop synchroniser and then an edge detector. The third rising clock edge after a rising edge of sync_in_i moves the count up to the nearest multiple of SYNC_US at or above its value, and restarts the prescaler.
- R8: An alignment jump that carries the count across a low-field boundary raises wrap_mark_o and increments the wrap counter, just as a normal rollover does.
- R9: In master mode sync_in_i has no effect on the count. In slave mode sync_out_o is held low.
- R10: While rst_ni is low the count and both markers are zero, and sync_out_o is high in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ts_reset_i | input | 1 | One-cycle timestamp-reset command |
| sync_master_i | input | 1 | 1 = drive the sync clock, 0 = follow the external sync clock |
| sync_in_i | input | 1 | External 10 kHz sync clock (asynchronous) |
| sync_out_o | output | 1 | 10 kHz sync clock driven in master mode |
| ts_low_o | output | TS_LOW_W | Low field of the count for tagging events |
| ts_full_o | output | TS_LOW_W+WRAP_W | Wrap counter joined to the low field |
| wrap_mark_o | output | 1 | One-cycle pulse on a low-field rollover |
| reset_mark_o | output | 1 | One-cycle pulse after a reset command |

## Verification
Two events can compete for the same clock edge: a timestamp reset and a low-field rollover. The bench runs the count up to all-ones in the low field, leaves the prescaler one edge short of a tick, and issues the reset command on exactly that edge. The result is judged correct only if the count reads zero, the reset marker is high and no wrap marker appears. A second overlap, an alignment jump that itself crosses the rollover, is provoked near the top of the low field. It must raise the wrap marker with the count landing on the expected multiple of 100.

// File: rtl/ust_pkg.sv
package ust_pkg;

  // Distance to the next multiple of period at or above the current phase.
  function automatic int unsigned mark_step(int unsigned phase, int unsigned period);
    return (phase == 0) ? 0 : period - phase;
  endfunction

  // Master sync level: first half of each period high.
  function automatic logic half_high(int unsigned phase, int unsigned period);
    return phase < (period / 2);
  endfunction

endpackage

// File: rtl/ust_prescaler.sv
module ust_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == PRE_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (tick_o)        cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < DIV) else $error("prescaler out of range"); // R1

endmodule

// File: rtl/ust_phase.sv
module ust_phase
  import ust_pkg::*;
#(
  parameter int SYNC_US = 100,
  parameter int PH_W    = $clog2(SYNC_US)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clr_i,
  input  logic            master_i,
  input  logic            sync_in_i,
  output logic            align_o,
  output logic [PH_W-1:0] step_o,
  output logic            sync_out_o
);
  logic [PH_W-1:0] ph_q;
  logic [2:0]      sy_q;
  logic            ext_rise;

  assign ext_rise   = sy_q[1] & ~sy_q[2];
  assign align_o    = ext_rise & ~master_i;
  assign step_o     = PH_W'(mark_step(32'(ph_q), SYNC_US));
  assign sync_out_o = master_i & half_high(32'(ph_q), SYNC_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q <= '0;
    end else begin
      sy_q <= {sy_q[1:0], sync_in_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (clr_i || align_o)  ph_q <= '0;
    else if (tick_i)            ph_q <= (ph_q == PH_W'(SYNC_US - 1)) ? '0 : ph_q + 1'b1;
  end

  AST_PH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ph_q) < SYNC_US) else $error("phase out of range"); // R6

endmodule

// File: rtl/ust_count.sv
module ust_count #(
  parameter int TS_LOW_W = 15,
  parameter int WRAP_W   = 17,
  parameter int PH_W     = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         clr_i,
  input  logic                         align_i,
  input  logic [PH_W-1:0]              step_i,
  output logic [TS_LOW_W+WRAP_W-1:0]   full_o,
  output logic                         wrap_mark_o,
  output logic                         reset_mark_o
);
  localparam int FULL_W = TS_LOW_W + WRAP_W;

  logic [FULL_W-1:0] inc, nxt;
  logic              carry_up;

  always_comb begin
    inc      = align_i ? FULL_W'(step_i) : FULL_W'(tick_i);
    nxt      = full_o + inc;
    carry_up = (nxt[FULL_W-1:TS_LOW_W] != full_o[FULL_W-1:TS_LOW_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o       <= '0;
      wrap_mark_o  <= 1'b0;
      reset_mark_o <= 1'b0;
    end else if (clr_i) begin
      full_o       <= '0;
      wrap_mark_o  <= 1'b0;
      reset_mark_o <= 1'b1;
    end else begin
      full_o       <= nxt;
      wrap_mark_o  <= carry_up;
      reset_mark_o <= 1'b0;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !align_i) |=> (full_o == $past(full_o) + 1'b1))
    else $error("count did not advance by one"); // R1

  AST_WRAP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_mark_o |-> (full_o[FULL_W-1:TS_LOW_W] ==
                     WRAP_W'($past(full_o[FULL_W-1:TS_LOW_W]) + 1'b1)))
    else $error("wrap marker without wrap counter step"); // R3

endmodule

// File: rtl/ust_timestamp_gen.sv
module ust_timestamp_gen #(
  parameter int CLK_PER_US = 100,
  parameter int TS_LOW_W   = 15,
  parameter int WRAP_W     = 17,
  parameter int SYNC_US    = 100
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ts_reset_i,
  input  logic                         sync_master_i,
  input  logic                         sync_in_i,
  output logic                         sync_out_o,
  output logic [TS_LOW_W-1:0]          ts_low_o,
  output logic [TS_LOW_W+WRAP_W-1:0]   ts_full_o,
  output logic                         wrap_mark_o,
  output logic                         reset_mark_o
);
  localparam int PH_W = $clog2(SYNC_US);

  logic            us_tick;
  logic            align;
  logic [PH_W-1:0] align_step;

  ust_prescaler #(.DIV(CLK_PER_US)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ts_reset_i | align),
    .tick_o    (us_tick)
  );

  ust_phase #(.SYNC_US(SYNC_US), .PH_W(PH_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (us_tick),
    .clr_i      (ts_reset_i),
    .master_i   (sync_master_i),
    .sync_in_i  (sync_in_i),
    .align_o    (align),
    .step_o     (align_step),
    .sync_out_o (sync_out_o)
  );

  ust_count #(.TS_LOW_W(TS_LOW_W), .WRAP_W(WRAP_W), .PH_W(PH_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (us_tick),
    .clr_i        (ts_reset_i),
    .align_i      (align),
    .step_i       (align_step),
    .full_o       (ts_full_o),
    .wrap_mark_o  (wrap_mark_o),
    .reset_mark_o (reset_mark_o)
  );

  assign ts_low_o = ts_full_o[TS_LOW_W-1:0];

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mark_o |-> (ts_full_o == '0)) else $error("reset marker with nonzero count"); // R4

  AST_RESET_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mark_o |-> !wrap_mark_o) else $error("wrap marker beside reset marker"); // R5

  AST_ALIGN_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align && !ts_reset_i) |=> ((ts_full_o % SYNC_US) == 0))
    else $error("alignment off a sync boundary"); // R7

  AST_MASTER_WAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_master_i |-> (sync_out_o == ((ts_full_o % SYNC_US) < (SYNC_US / 2))))
    else $error("master wave not locked to count"); // R6

endmodule

// File: tb/ust_timestamp_gen_bench.sv
module ust_timestamp_gen_bench;
  localparam int DIV = 4;
  localparam int LW  = 10;
  localparam int WW  = 22;
  localparam int SP  = 100;
  localparam int FW  = LW + WW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tsr;
  logic          master;
  logic          sync_in;
  logic          sync_out;
  logic [LW-1:0] ts_low;
  logic [FW-1:0] ts_full;
  logic          wrap_mark;
  logic          reset_mark;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ust_timestamp_gen #(.CLK_PER_US(DIV), .TS_LOW_W(LW), .WRAP_W(WW), .SYNC_US(SP)) u_ust_timestamp_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ts_reset_i    (tsr),
    .sync_master_i (master),
    .sync_in_i     (sync_in),
    .sync_out_o    (sync_out),
    .ts_low_o      (ts_low),
    .ts_full_o     (ts_full),
    .wrap_mark_o   (wrap_mark),
    .reset_mark_o  (reset_mark)
  );

  // edges after release, expected count, expected wrap marker
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{1, 0, 0}, '{3, 0, 0}, '{4, 1, 0}, '{7, 1, 0}, '{8, 2, 0},
    '{400, 100, 0}, '{4095, 1023, 0}, '{4096, 1024, 1}, '{4097, 1024, 0}, '{4100, 1025, 0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ts_cmd();
    tsr = 1'b1;
    step(1);
    tsr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cur;
    rst_n = 1'b0; tsr = 1'b0; master = 1'b1; sync_in = 1'b0;
    step(3);
    chk("R10 count", ts_full, 0);
    chk("R10 wrap", wrap_mark, 0);
    chk("R10 reset mark", reset_mark, 0);
    chk("R10 sync out", sync_out, 1);
    rst_n = 1'b1;
    cur = 0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][0] - cur);
      cur = VEC[i][0];
      chk("R1 count", ts_full, VEC[i][1]);
      chk("R2 low field", ts_low, VEC[i][1] % (1 << LW));
      chk("R3 wrap marker", wrap_mark, VEC[i][2]);
      chk("R6 master wave", sync_out, ((VEC[i][1] % SP) < (SP / 2)) ? 1 : 0);
    end

    // R4: reset command
    ts_cmd();
    chk("R4 reset mark", reset_mark, 1);
    chk("R4 cleared", ts_full, 0);
    chk("R4 no wrap", wrap_mark, 0);
    step(1);
    chk("R4 mark one cycle", reset_mark, 0);
    step(2);
    chk("R4 restart hold", ts_full, 0);
    step(1);
    chk("R4 first tick", ts_full, 1);

    // R5: reset lands on the rollover tick
    ts_cmd();
    step(4095);
    chk("R5 before collide", ts_full, 1023);
    ts_cmd();
    chk("R5 reset mark", reset_mark, 1);
    chk("R5 no wrap", wrap_mark, 0);
    chk("R5 count zero", ts_full, 0);

    // R9: master mode ignores sync_in
    step(150);
    sync_in = 1'b1;
    step(3);
    chk("R9 master ignores sync", ts_full, 38);
    sync_in = 1'b0;
    step(3);

    // R7: slave alignment
    master = 1'b0;
    ts_cmd();
    chk("R9 slave sync low", sync_out, 0);
    step(150);
    chk("R1 pre-align", ts_full, 37);
    sync_in = 1'b1;
    step(2);
    chk("R7 synchroniser delay", ts_full, 38);
    step(1);
    chk("R7 aligned", ts_full, 100);
    chk("R7 no wrap", wrap_mark, 0);
    chk("R9 slave sync low", sync_out, 0);
    step(3);
    chk("R7 prescaler restart", ts_full, 100);
    step(1);
    chk("R7 next tick", ts_full, 101);

    // R8: alignment crossing the low-field boundary
    sync_in = 1'b0;
    step(3);
    ts_cmd();
    step(4076);
    chk("R8 pre-align", ts_full, 1019);
    sync_in = 1'b1;
    step(3);
    chk("R8 aligned count", ts_full, 1100);
    chk("R8 low field", ts_low, 76);
    chk("R8 wrap marker", wrap_mark, 1);
    step(1);
    chk("R8 marker one cycle", wrap_mark, 0);

    finish_run();
  end

endmodule